// File: doc/BRIEF.md
# Card Transaction Sequencer

This block walks one memory-card request through its phases: the main command, an optional data phase, a busy wait for data completion, and an optional stop command. Other logic drives the card bus, moves the data and checks CRCs. This block only consumes the completion and error pulses that logic produces, along with the status words captured with them. It drives a one-cycle issue strobe, and a qualifier that says whether the strobe asks for the main command or the stop command.

When a request finishes, the block pulses `done` once. At that point it presents a 2-bit error code for each of the command, data and stop phases, a no-medium flag for each phase, and the byte count of a clean transfer. A card-removed input aborts a request in flight. The flags it sets depend on the phase the request had reached.

Event pulses are held as pending bits until the state that uses them is reached. All events present in a cycle are resolved in a single pass through the states, so several phases can close in the same cycle.

Top module: `card_txn_seq`

## Requirements
- R1: After reset the block is idle: `busy`, `done` and `cmd_issue` are 0, and every error code, no-medium flag and the byte count are 0.
- R2: `req_start` while idle latches the request options, clears all results and pending events, and in the next cycle raises `busy` and a one-cycle `cmd_issue` with `cmd_is_stop` = 0.
- R3: On command completion, the request ends if the command error code is not 0 or the request has no data phase. Otherwise the data phase begins.
- R4: The command and stop error codes are 1 (timeout) if status bit 0 is set. Otherwise they are 2 (CRC) if bit 1 is set and `req_crc_chk` was set at start. Otherwise they are 3 (I/O) if any of bits 2, 3 or 4 (index, direction, end bit) is set. Otherwise they are 0.
- R5: In the data phase a data-error event wins over transfer completion. It issues the stop (`cmd_issue` with `cmd_is_stop` = 1) when the request has one. The block then waits for transfer completion before it waits for data completion.
- R6: On data completion the data error code is 1 if data status bit 0 (timeout) is set. Otherwise it is 2 if bit 1 (CRC) is set. Otherwise it is 3 if bit 2 (overrun) or bit 3 (underrun) is set. Otherwise it is 0.
- R7: A data completion with code 0 sets `bytes_done` to blocks times block length. Without a stop command the request then ends.
- R8: With a stop command and a clean data phase, data completion issues the stop. The next command completion sets the stop error code (R4) and ends the request.
- R9: With a stop command and a data error, data completion issues no further command. The request ends on the following command completion.
- R10: Card removal while busy ends the request in the next cycle and sets flags by state. While the main command is pending it flags the command, and the data too if present. In the data phase it flags the data. While waiting for data completion or transfer completion after an error, it flags the data and, if present, the stop. While the stop is pending it flags the stop.
- R11: An event arriving before its state is reached is kept and used later. Events in one cycle are resolved in one pass, so one cycle can finish a whole request.
- R12: While idle, events and card removal are ignored: no `done`, no issue, `busy` stays 0.
- R13: `done` is a single-cycle pulse, and `busy` is 0 from the cycle `done` is high.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_start | input | 1 | Start a request (taken only while idle) |
| req_has_data | input | 1 | Request has a data phase |
| req_has_stop | input | 1 | Request ends with a stop command |
| req_crc_chk | input | 1 | Response CRC is expected |
| req_blocks | input | CNT_W | Number of blocks |
| req_blk_len | input | BLK_W | Block length in bytes |
| ev_cmd_done | input | 1 | Command (main or stop) completed |
| ev_xfer_done | input | 1 | All data moved |
| ev_data_done | input | 1 | Card left busy, data phase complete |
| ev_data_err | input | 1 | Data error seen during transfer |
| cmd_status | input | 5 | Status captured with command completion |
| data_status | input | 4 | Status captured with data completion or error |
| card_removed | input | 1 | Card gone, abort the request |
| busy | output | 1 | Request in flight |
| cmd_issue | output | 1 | One-cycle command issue strobe |
| cmd_is_stop | output | 1 | Issue strobe is for the stop command |
| done | output | 1 | One-cycle request end pulse |
| cmd_err | output | 2 | Main command error code |
| data_err | output | 2 | Data phase error code |
| stop_err | output | 2 | Stop command error code |
| no_med_cmd | output | 1 | Command ended by card removal |
| no_med_data | output | 1 | Data ended by card removal |
| no_med_stop | output | 1 | Stop ended by card removal |
| bytes_done | output | CNT_W+BLK_W | Bytes moved by a clean data phase |

## Verification
The bench builds the block with a 4-bit block count and a 6-bit block length. This makes the largest product, 15 times 63, reachable, so a truncated byte-count width would show. The narrow widths also keep every status pattern of both classifiers cheap to drive. Each of the five states can be reached and then aborted by removal within a few cycles. This covers all the removal marking cases and the single-cycle resolution of bunched events.

// File: rtl/cts_pkg.sv
package cts_pkg;
  localparam int CSW = 5;
  localparam int DSW = 4;
  localparam int NEV = 4;
  localparam int EV_CMD  = 0;
  localparam int EV_XFER = 1;
  localparam int EV_DDONE = 2;
  localparam int EV_DERR = 3;

  typedef enum logic [2:0] {
    ST_IDLE, ST_CMD, ST_DATA, ST_BUSY, ST_STOP, ST_DERR
  } seq_st_t;

  localparam int NPASS = 5;

  typedef enum logic [1:0] {
    EC_NONE = 2'd0, EC_TMO = 2'd1, EC_CRC = 2'd2, EC_IO = 2'd3
  } err_code_t;
endpackage

// File: rtl/cts_err_classify.sv
module cts_err_classify #(
  parameter int SW = 5
) (
  input  logic [SW-1:0] stat,
  input  logic          crc_en,
  output logic [1:0]    code
);
  import cts_pkg::*;
  logic t_hit, c_hit, io_hit;
  always_comb begin
    t_hit  = stat[0];
    c_hit  = stat[1] & crc_en;
    io_hit = |stat[SW-1:2];
    if (t_hit)       code = EC_TMO;
    else if (c_hit)  code = EC_CRC;
    else if (io_hit) code = EC_IO;
    else             code = EC_NONE;
  end
endmodule

// File: rtl/cts_event_latch.sv
module cts_event_latch
  import cts_pkg::*;
#(
  parameter int NE = NEV,
  parameter int CW = CSW,
  parameter int DW = DSW
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          arm,
  input  logic [NE-1:0] ev_in,
  input  logic [NE-1:0] pend_nxt,
  input  logic [CW-1:0] cstat_in,
  input  logic [DW-1:0] dstat_in,
  output logic [NE-1:0] ev_eff,
  output logic [CW-1:0] cstat_eff,
  output logic [DW-1:0] dstat_eff
);
  logic [NE-1:0] pend_q;
  logic [CW-1:0] cstat_q;
  logic [DW-1:0] dstat_q;
  logic          cap_c, cap_d;

  assign cap_c     = ev_in[EV_CMD];
  assign cap_d     = ev_in[EV_DDONE] | ev_in[EV_DERR];
  assign ev_eff    = pend_q | (ev_in & {NE{arm}});
  assign cstat_eff = cap_c ? cstat_in : cstat_q;
  assign dstat_eff = cap_d ? dstat_in : dstat_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      pend_q  <= '0;
      cstat_q <= '0;
      dstat_q <= '0;
    end else begin
      pend_q  <= pend_nxt;
      cstat_q <= cstat_eff;
      dstat_q <= dstat_eff;
    end
  end
endmodule

// File: rtl/card_txn_seq.sv
module card_txn_seq
  import cts_pkg::*;
#(
  parameter int CNT_W = 9,
  parameter int BLK_W = 16
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   req_start,
  input  logic                   req_has_data,
  input  logic                   req_has_stop,
  input  logic                   req_crc_chk,
  input  logic [CNT_W-1:0]       req_blocks,
  input  logic [BLK_W-1:0]       req_blk_len,
  input  logic                   ev_cmd_done,
  input  logic                   ev_xfer_done,
  input  logic                   ev_data_done,
  input  logic                   ev_data_err,
  input  logic [4:0]             cmd_status,
  input  logic [3:0]             data_status,
  input  logic                   card_removed,
  output logic                   busy,
  output logic                   cmd_issue,
  output logic                   cmd_is_stop,
  output logic                   done,
  output logic [1:0]             cmd_err,
  output logic [1:0]             data_err,
  output logic [1:0]             stop_err,
  output logic                   no_med_cmd,
  output logic                   no_med_data,
  output logic                   no_med_stop,
  output logic [CNT_W+BLK_W-1:0] bytes_done
);
  localparam int BYTES_W = CNT_W + BLK_W;

  seq_st_t              state_q, state_n;
  logic                 has_data_q, has_stop_q, crc_q;
  logic [CNT_W-1:0]     blocks_q;
  logic [BLK_W-1:0]     blk_len_q;
  logic                 issue_n, is_stop_n, done_n;
  logic [1:0]           cerr_n, derr_n, serr_n;
  logic                 nm_c_n, nm_d_n, nm_s_n;
  logic [BYTES_W-1:0]   bytes_n, bytes_full;
  logic [NEV-1:0]       ev_raw, ev_eff, pend_nxt;
  logic [CSW-1:0]       cstat_eff;
  logic [DSW-1:0]       dstat_eff;
  logic [1:0]           ccode, dcode;

  assign ev_raw     = {ev_data_err, ev_data_done, ev_xfer_done, ev_cmd_done};
  assign busy       = (state_q != ST_IDLE);
  assign bytes_full = BYTES_W'(blocks_q) * BYTES_W'(blk_len_q);

  cts_event_latch #(.NE(NEV), .CW(CSW), .DW(DSW)) u_evl (
    .clk(clk), .rst(rst), .arm(busy), .ev_in(ev_raw), .pend_nxt(pend_nxt),
    .cstat_in(cmd_status), .dstat_in(data_status),
    .ev_eff(ev_eff), .cstat_eff(cstat_eff), .dstat_eff(dstat_eff)
  );

  cts_err_classify #(.SW(CSW)) u_ccls (
    .stat(cstat_eff), .crc_en(crc_q), .code(ccode)
  );

  cts_err_classify #(.SW(DSW)) u_dcls (
    .stat(dstat_eff), .crc_en(1'b1), .code(dcode)
  );

  always_comb begin
    seq_st_t st;
    logic pc, px, pd, pe;
    st = state_q;
    {pe, pd, px, pc} = ev_eff;
    issue_n   = 1'b0;
    is_stop_n = cmd_is_stop;
    done_n    = 1'b0;
    cerr_n    = cmd_err;
    derr_n    = data_err;
    serr_n    = stop_err;
    nm_c_n    = no_med_cmd;
    nm_d_n    = no_med_data;
    nm_s_n    = no_med_stop;
    bytes_n   = bytes_done;
    if (state_q == ST_IDLE) begin
      if (req_start) begin
        st = ST_CMD;
        issue_n = 1'b1;
        is_stop_n = 1'b0;
        cerr_n = EC_NONE;
        derr_n = EC_NONE;
        serr_n = EC_NONE;
        {nm_c_n, nm_d_n, nm_s_n} = 3'b000;
        bytes_n = '0;
      end
    end else if (card_removed) begin
      case (state_q)
        ST_CMD:  begin nm_c_n = 1'b1; nm_d_n = has_data_q; end
        ST_DATA: nm_d_n = 1'b1;
        ST_BUSY, ST_DERR: begin nm_d_n = 1'b1; nm_s_n = has_stop_q; end
        ST_STOP: nm_s_n = 1'b1;
        default: ;
      endcase
      st = ST_IDLE;
      done_n = 1'b1;
    end else begin
      for (int i = 0; i < NPASS; i++) begin
        case (st)
          ST_CMD: if (pc) begin
            pc = 1'b0;
            cerr_n = ccode;
            if (!has_data_q || ccode != EC_NONE) begin
              st = ST_IDLE; done_n = 1'b1;
            end else st = ST_DATA;
          end
          ST_DATA: if (pe) begin
            pe = 1'b0;
            if (has_stop_q) begin issue_n = 1'b1; is_stop_n = 1'b1; end
            st = ST_DERR;
          end else if (px) begin
            px = 1'b0;
            st = ST_BUSY;
          end
          ST_DERR: if (px) begin
            px = 1'b0;
            st = ST_BUSY;
          end
          ST_BUSY: if (pd) begin
            pd = 1'b0;
            derr_n = dcode;
            if (dcode == EC_NONE) bytes_n = bytes_full;
            if (!has_stop_q) begin
              st = ST_IDLE; done_n = 1'b1;
            end else begin
              st = ST_STOP;
              if (dcode == EC_NONE) begin issue_n = 1'b1; is_stop_n = 1'b1; end
            end
          end
          ST_STOP: if (pc) begin
            pc = 1'b0;
            serr_n = ccode;
            st = ST_IDLE; done_n = 1'b1;
          end
          default: ;
        endcase
      end
    end
    if (st == ST_IDLE) {pe, pd, px, pc} = '0;
    state_n  = st;
    pend_nxt = {pe, pd, px, pc};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      state_q     <= ST_IDLE;
      has_data_q  <= 1'b0;
      has_stop_q  <= 1'b0;
      crc_q       <= 1'b0;
      blocks_q    <= '0;
      blk_len_q   <= '0;
      cmd_issue   <= 1'b0;
      cmd_is_stop <= 1'b0;
      done        <= 1'b0;
      cmd_err     <= 2'd0;
      data_err    <= 2'd0;
      stop_err    <= 2'd0;
      no_med_cmd  <= 1'b0;
      no_med_data <= 1'b0;
      no_med_stop <= 1'b0;
      bytes_done  <= '0;
    end else begin
      if (state_q == ST_IDLE && req_start) begin
        has_data_q <= req_has_data;
        has_stop_q <= req_has_stop;
        crc_q      <= req_crc_chk;
        blocks_q   <= req_blocks;
        blk_len_q  <= req_blk_len;
      end
      state_q     <= state_n;
      cmd_issue   <= issue_n;
      cmd_is_stop <= is_stop_n;
      done        <= done_n;
      cmd_err     <= cerr_n;
      data_err    <= derr_n;
      stop_err    <= serr_n;
      no_med_cmd  <= nm_c_n;
      no_med_data <= nm_d_n;
      no_med_stop <= nm_s_n;
      bytes_done  <= bytes_n;
    end
  end
endmodule

// File: rtl/cts_chk.sv
module cts_chk (
  input logic clk,
  input logic rst,
  input logic req_start,
  input logic card_removed,
  input logic busy,
  input logic done,
  input logic cmd_issue,
  input logic cmd_is_stop
);
  // R13
  done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
    done |=> !done);

  // R13
  done_idle_chk: assert property (@(posedge clk) disable iff (rst)
    done |-> !busy);

  // R2
  start_issue_chk: assert property (@(posedge clk) disable iff (rst)
    (req_start && !busy) |=> (cmd_issue && !cmd_is_stop && busy));

  // R10
  remove_abort_chk: assert property (@(posedge clk) disable iff (rst)
    (card_removed && busy) |=> (done && !busy));

  // R12
  idle_hold_chk: assert property (@(posedge clk) disable iff (rst)
    (!busy && !req_start) |=> (!busy && !done && !cmd_issue));
endmodule

bind card_txn_seq cts_chk u_chk (
  .clk(clk), .rst(rst), .req_start(req_start), .card_removed(card_removed),
  .busy(busy), .done(done), .cmd_issue(cmd_issue), .cmd_is_stop(cmd_is_stop)
);

// File: tb/card_txn_seq_test.sv
module card_txn_seq_test;
  localparam int CW = 4;
  localparam int BW = 6;
  localparam int YW = CW + BW;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic req_start = 0, req_has_data = 0, req_has_stop = 0, req_crc_chk = 0;
  logic [CW-1:0] req_blocks = '0;
  logic [BW-1:0] req_blk_len = '0;
  logic ev_cmd_done = 0, ev_xfer_done = 0, ev_data_done = 0, ev_data_err = 0;
  logic [4:0] cmd_status = '0;
  logic [3:0] data_status = '0;
  logic card_removed = 0;
  logic busy, cmd_issue, cmd_is_stop, done;
  logic [1:0] cmd_err, data_err, stop_err;
  logic no_med_cmd, no_med_data, no_med_stop;
  logic [YW-1:0] bytes_done;

  int checks = 0;
  int errors = 0;

  typedef struct packed {
    logic [1:0] ce;
    logic [1:0] de;
    logic [1:0] se;
    logic [2:0] nm;
    logic [YW-1:0] by;
  } res_t;

  res_t  exp_q[$];
  string tag_q[$];

  always #2 clk = ~clk;

  card_txn_seq #(.CNT_W(CW), .BLK_W(BW)) uut (
    .clk(clk), .rst(rst), .req_start(req_start), .req_has_data(req_has_data),
    .req_has_stop(req_has_stop), .req_crc_chk(req_crc_chk), .req_blocks(req_blocks),
    .req_blk_len(req_blk_len), .ev_cmd_done(ev_cmd_done), .ev_xfer_done(ev_xfer_done),
    .ev_data_done(ev_data_done), .ev_data_err(ev_data_err), .cmd_status(cmd_status),
    .data_status(data_status), .card_removed(card_removed), .busy(busy),
    .cmd_issue(cmd_issue), .cmd_is_stop(cmd_is_stop), .done(done), .cmd_err(cmd_err),
    .data_err(data_err), .stop_err(stop_err), .no_med_cmd(no_med_cmd),
    .no_med_data(no_med_data), .no_med_stop(no_med_stop), .bytes_done(bytes_done)
  );

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  function automatic logic [1:0] cmd_code(input logic [4:0] s, input bit crc);
    if (s[0]) return 2'd1;
    if (s[1] && crc) return 2'd2;
    if (s[2] || s[3] || s[4]) return 2'd3;
    return 2'd0;
  endfunction

  function automatic logic [1:0] dat_code(input logic [3:0] s);
    if (s[0]) return 2'd1;
    if (s[1]) return 2'd2;
    if (s[2] || s[3]) return 2'd3;
    return 2'd0;
  endfunction

  task automatic expect_res(input logic [1:0] ce, de, se, input logic [2:0] nm,
                            input int by, input string tag);
    res_t r;
    r.ce = ce; r.de = de; r.se = se; r.nm = nm; r.by = YW'(by);
    exp_q.push_back(r);
    tag_q.push_back(tag);
  endtask

  // scoreboard monitor
  always @(negedge clk) begin
    if (!rst && done) begin
      if (exp_q.size() == 0) begin
        chk(1'b0, "R13 unexpected done", 1, 0);
      end else begin
        res_t e, a;
        string t;
        e = exp_q.pop_front();
        t = tag_q.pop_front();
        a.ce = cmd_err; a.de = data_err; a.se = stop_err;
        a.nm = {no_med_cmd, no_med_data, no_med_stop}; a.by = bytes_done;
        chk(a == e, t, 32'(a), 32'(e));
      end
    end
  end

  task automatic start(input bit hd, hs, ce, input int nb, bs);
    @(negedge clk);
    req_start = 1; req_has_data = hd; req_has_stop = hs; req_crc_chk = ce;
    req_blocks = CW'(nb); req_blk_len = BW'(bs);
    @(negedge clk);
    req_start = 0;
    chk(cmd_issue === 1'b1 && cmd_is_stop === 1'b0 && busy === 1'b1,
        "R2 main issue and busy", {cmd_issue, cmd_is_stop, busy}, 3'b101);
    @(negedge clk);
    chk(cmd_issue === 1'b0, "R13 issue strobe one cycle", cmd_issue, 0);
  endtask

  // ev bits: {derr, ddone, xfer, cmd}
  task automatic pulse(input logic [3:0] ev, input logic [4:0] cs, input logic [3:0] ds);
    @(negedge clk);
    {ev_data_err, ev_data_done, ev_xfer_done, ev_cmd_done} = ev;
    cmd_status = cs; data_status = ds;
    @(negedge clk);
    {ev_data_err, ev_data_done, ev_xfer_done, ev_cmd_done} = '0;
  endtask

  task automatic remove();
    @(negedge clk); card_removed = 1;
    @(negedge clk); card_removed = 0;
  endtask

  task automatic ended(input string tag);
    chk(done === 1'b1 && busy === 1'b0, tag, {done, busy}, 2'b10);
    @(negedge clk);
    chk(done === 1'b0, "R13 done one cycle", done, 0);
  endtask

  task automatic still_busy(input string tag);
    chk(busy === 1'b1 && done === 1'b0, tag, {busy, done}, 2'b10);
  endtask

  task automatic run_cmd_only(input bit crc, input logic [4:0] cs, input string tag);
    start(0, 0, crc, 0, 0);
    expect_res(cmd_code(cs, crc), 0, 0, 0, 0, tag);
    pulse(4'b0001, cs, 0);
    ended({tag, " end"});
  endtask

  task automatic run_data_err_class(input logic [3:0] ds);
    start(1, 0, 0, 3, 5);
    pulse(4'b0001, 0, 0);
    pulse(4'b0010, 0, 0);
    expect_res(0, dat_code(ds), 0, 0, 0, "R6 data error priority");
    pulse(4'b0100, 0, ds);
    ended("R6 end");
  endtask

  initial begin
    repeat (40000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired actual=1 expected=0");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    @(negedge clk);
    // R1 reset state
    chk(busy === 0 && done === 0 && cmd_issue === 0, "R1 idle after reset",
        {busy, done, cmd_issue}, 0);
    chk(cmd_err === 0 && data_err === 0 && stop_err === 0 && bytes_done === 0 &&
        no_med_cmd === 0 && no_med_data === 0 && no_med_stop === 0,
        "R1 results cleared", {cmd_err, data_err, stop_err}, 0);

    // R12 events and removal while idle are ignored
    pulse(4'b1111, 5'b00001, 4'b0001);
    chk(busy === 0 && done === 0 && cmd_issue === 0, "R12 idle events ignored",
        {busy, done, cmd_issue}, 0);
    remove();
    chk(busy === 0 && done === 0, "R12 idle removal ignored", {busy, done}, 0);

    // R3 / R4 command classification without data
    run_cmd_only(1, 5'b00000, "R4 clean command");
    run_cmd_only(1, 5'b00011, "R4 timeout beats crc");
    run_cmd_only(1, 5'b00110, "R4 crc beats index");
    run_cmd_only(0, 5'b00110, "R4 crc ignored when not expected");
    run_cmd_only(0, 5'b01000, "R4 direction is io");
    run_cmd_only(0, 5'b10000, "R4 end bit is io");

    // R3 command error ends a data request
    start(1, 1, 0, 4, 8);
    expect_res(1, 0, 0, 0, 0, "R3 command error skips data");
    pulse(4'b0001, 5'b00001, 0);
    ended("R3 end on command error");

    // R7 clean data, no stop, largest product
    start(1, 0, 0, 15, 63);
    pulse(4'b0001, 0, 0);
    still_busy("R3 data phase entered");
    pulse(4'b0010, 0, 0);
    still_busy("R7 waiting data completion");
    expect_res(0, 0, 0, 0, 945, "R7 byte count 15x63");
    pulse(4'b0100, 0, 0);
    ended("R7 end without stop");

    // R11 all events in one cycle
    start(1, 0, 0, 2, 16);
    expect_res(0, 0, 0, 0, 32, "R11 single cycle request");
    pulse(4'b0111, 0, 0);
    ended("R11 one pass completion");

    // R11 early data completion kept until transfer completion
    start(1, 0, 0, 1, 4);
    pulse(4'b0001, 0, 0);
    pulse(4'b0100, 0, 0);
    still_busy("R11 early data done held");
    expect_res(0, 0, 0, 0, 4, "R11 pending data done used");
    pulse(4'b0010, 0, 0);
    ended("R11 end after transfer");

    // R6 data classification
    run_data_err_class(4'b0011);
    run_data_err_class(4'b0110);
    run_data_err_class(4'b1000);

    // R8 clean data with stop
    start(1, 1, 1, 2, 8);
    pulse(4'b0001, 0, 0);
    pulse(4'b0010, 0, 0);
    pulse(4'b0100, 0, 0);
    chk(cmd_issue === 1 && cmd_is_stop === 1 && busy === 1, "R8 stop issued",
        {cmd_issue, cmd_is_stop, busy}, 3'b111);
    expect_res(0, 0, 2, 0, 16, "R8 stop crc error");
    pulse(4'b0001, 5'b00010, 0);
    ended("R8 end on stop completion");

    // R5 / R9 data error with stop, error beats transfer completion
    start(1, 1, 0, 2, 8);
    pulse(4'b0001, 0, 0);
    pulse(4'b1010, 0, 4'b0100);
    chk(cmd_issue === 1 && cmd_is_stop === 1, "R5 stop issued on data error",
        {cmd_issue, cmd_is_stop}, 2'b11);
    still_busy("R5 still busy after error");
    pulse(4'b0100, 0, 4'b0100);
    chk(cmd_issue === 0 && busy === 1, "R9 no second stop", {cmd_issue, busy}, 2'b01);
    expect_res(0, 3, 0, 0, 0, "R9 error then stop end");
    pulse(4'b0001, 0, 0);
    ended("R9 end on stop completion");

    // R5 data error waits for transfer completion
    start(1, 0, 0, 2, 8);
    pulse(4'b0001, 0, 0);
    pulse(4'b1000, 0, 4'b0001);
    chk(cmd_issue === 0, "R5 no stop without stop command", cmd_issue, 0);
    pulse(4'b0100, 0, 4'b0001);
    still_busy("R5 waits for transfer completion");
    expect_res(0, 1, 0, 0, 0, "R5 error path end");
    pulse(4'b0010, 0, 0);
    ended("R5 end after transfer");

    // R10 removal in each state
    start(1, 0, 0, 1, 1);
    expect_res(0, 0, 0, 3'b110, 0, "R10 removal while command with data");
    remove(); ended("R10 abort command");

    start(0, 0, 0, 0, 0);
    expect_res(0, 0, 0, 3'b100, 0, "R10 removal while command only");
    remove(); ended("R10 abort command only");

    start(1, 1, 0, 1, 1);
    pulse(4'b0001, 0, 0);
    expect_res(0, 0, 0, 3'b010, 0, "R10 removal in data phase");
    remove(); ended("R10 abort data");

    start(1, 1, 0, 1, 1);
    pulse(4'b0001, 0, 0);
    pulse(4'b0010, 0, 0);
    expect_res(0, 0, 0, 3'b011, 0, "R10 removal in data busy with stop");
    remove(); ended("R10 abort busy");

    start(1, 0, 0, 1, 1);
    pulse(4'b0001, 0, 0);
    pulse(4'b1000, 0, 4'b0010);
    expect_res(0, 0, 0, 3'b010, 0, "R10 removal after data error");
    remove(); ended("R10 abort data error");

    start(1, 1, 0, 2, 8);
    pulse(4'b0001, 0, 0);
    pulse(4'b0010, 0, 0);
    pulse(4'b0100, 0, 0);
    expect_res(0, 0, 0, 3'b001, 16, "R10 removal while stop pending");
    remove(); ended("R10 abort stop");

    repeat (3) @(negedge clk);
    chk(exp_q.size() == 0, "R13 every expected result seen", exp_q.size(), 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule